// File: doc/BRIEF.md
# UART Transmit Channel with Command-Sequenced Break

This block is the transmit side of one UART channel. Software writes characters into a one-entry holding register. A shift register behind it sends each character as a 10-bit frame: one start bit, eight data bits least significant bit first, and one stop bit. The frame moves one bit on every pulse of an external bit-rate strobe.

An 8-bit command register controls the channel. Its transmitter-control field enables or disables the transmitter. Its miscellaneous field resets the transmitter, starts or ends a line break, clears the break-change flag, and sends one-cycle reset pulses to neighbouring receiver and mode logic.

Break handling is tied to the two buffer stages. A break never cuts a frame short. A character that is waiting in the holding register goes out only after the break has ended and the line has been back at mark.

Top module: `uartb_tx_top`

## Requirements
- R1: After reset, and whenever the transmitter is disabled with no break active, `txd` is 1, `tx_ready` and `tx_empty` are 0, and `brk_delta` is 0 after reset.
- R2: A write with `wr_addr`=0 puts `wr_data` into the holding register. At the next `bit_tick` the character moves to the shift register and `txd` starts its frame: a 0 start bit, data bits 0 to 7, then a 1 stop bit. `txd` changes only on `bit_tick`.
- R3: `tx_ready` is 1 when the transmitter is enabled and the holding register is empty. `tx_empty` is 1 when, in addition, no frame is being shifted. A data write is ignored while the holding register is full or the transmitter is disabled.
- R4: Command (`wr_addr`=1) bits [3:2]=01 enables the transmitter, and the next cycle shows `tx_ready`=1. Enabling an already enabled transmitter changes nothing, and a held character is kept.
- R5: Bits [3:2]=10 disables the transmitter. `tx_ready` and `tx_empty` drop at once and the held character is dropped. A frame already shifting is finished. Disabling an already disabled transmitter changes nothing.
- R6: Bits [3:2]=11 has no effect, whether the transmitter is enabled or disabled.
- R7: Bits [6:4]=011 resets the transmitter. The frame is cut off at once, `txd` returns high, the transmitter is disabled and both flags clear. If the same write also carries enable (01), the reset is applied first and the enable second.
- R8: Bits [6:4]=110 sent while nothing is shifting drives `txd` low from the next `bit_tick`.
- R9: A break start (110) that arrives while a frame is shifting takes effect only after that frame's stop bit has been sent.
- R10: A break start is ignored while the transmitter is disabled.
- R11: Bits [6:4]=111 ends a break. `txd` goes high at the next `bit_tick` and stays high for at least that tick and the one after it. A held character's start bit follows at the third tick.
- R12: `brk_delta` is set each time the break state of the line changes. Bits [6:4]=101 clears it.
- R13: Bits [6:4]=001, 010 and 100 each produce a one-cycle pulse, on `mode_ptr_rst`, `rx_rst` and `err_rst` respectively. The pulse appears in the cycle after the write. The value 000 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = transmit data, 1 = command |
| wr_data | input | 8 | Write data |
| txd | output | 1 | Serial line output |
| tx_ready | output | 1 | Holding register can accept a character |
| tx_empty | output | 1 | Both buffer stages empty |
| brk_delta | output | 1 | Break-change flag |
| mode_ptr_rst | output | 1 | Pulse: point mode access at the first mode register |
| rx_rst | output | 1 | Pulse: reset receiver |
| err_rst | output | 1 | Pulse: reset error status |

## Verification
The hardest state to reach from the ports has three things true at once: a frame partly shifted out, a second character sitting in the holding register, and a break start pending behind both. The bench builds this state step by step. It pulses `bit_tick` once so the first character is loaded, writes the second character, and only then sends the break start. It then counts ticks to confirm three things in order: the stop bit of the first frame, the break, and, after the break stop, two ticks of mark followed by the held character's frame.

// File: rtl/uartb_pkg.sv
`timescale 1ns/1ps
package uartb_pkg;
  localparam int unsigned BUS_W   = 8;
  localparam int unsigned MISC_LO = 4;
  localparam int unsigned TC_LO   = 2;

  typedef enum logic [2:0] {
    MC_NOP    = 3'd0,
    MC_MPTR   = 3'd1,
    MC_RXRST  = 3'd2,
    MC_TXRST  = 3'd3,
    MC_ERRRST = 3'd4,
    MC_DBCLR  = 3'd5,
    MC_BRKON  = 3'd6,
    MC_BRKOFF = 3'd7
  } misc_cmd_e;

  typedef enum logic [1:0] {
    TC_KEEP = 2'd0,
    TC_ON   = 2'd1,
    TC_OFF  = 2'd2,
    TC_RSVD = 2'd3
  } txc_cmd_e;

  typedef struct packed {
    logic mptr;
    logic rxrst;
    logic txrst;
    logic errrst;
    logic dbclr;
    logic brkon;
    logic brkoff;
    logic txon;
    logic txoff;
  } cmd_strb_t;
endpackage

// File: rtl/uartb_cmd_dec.sv
`timescale 1ns/1ps
module uartb_cmd_dec
  import uartb_pkg::*;
(
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [BUS_W-1:0] wr_data,
  output logic             data_wr,
  output cmd_strb_t        strb
);
  misc_cmd_e misc;
  txc_cmd_e  tc;
  logic      cmd_wr;
  logic      unused_bits;

  assign unused_bits = ^{wr_data[BUS_W-1], wr_data[TC_LO-1:0]};
  assign data_wr = wr_en & ~wr_addr;
  assign cmd_wr  = wr_en &  wr_addr;
  assign misc    = misc_cmd_e'(wr_data[MISC_LO +: 3]);
  assign tc      = txc_cmd_e'(wr_data[TC_LO +: 2]);

  always_comb begin
    strb        = '0;
    strb.mptr   = cmd_wr & (misc == MC_MPTR);
    strb.rxrst  = cmd_wr & (misc == MC_RXRST);
    strb.txrst  = cmd_wr & (misc == MC_TXRST);
    strb.errrst = cmd_wr & (misc == MC_ERRRST);
    strb.dbclr  = cmd_wr & (misc == MC_DBCLR);
    strb.brkon  = cmd_wr & (misc == MC_BRKON);
    strb.brkoff = cmd_wr & (misc == MC_BRKOFF);
    strb.txon   = cmd_wr & (tc == TC_ON);
    strb.txoff  = cmd_wr & (tc == TC_OFF);
  end
endmodule

// File: rtl/uartb_shifter.sv
`timescale 1ns/1ps
module uartb_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_char,
  input  logic              abort,
  output logic              busy,
  output logic              last,
  output logic              line_bit
);
  localparam int unsigned FRAME_W = DATA_W + 2;
  localparam int unsigned CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] frame_q, frame_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic               busy_q, busy_n;

  always_comb begin
    frame_n = frame_q;
    cnt_n   = cnt_q;
    busy_n  = busy_q;
    if (abort) begin
      busy_n = 1'b0;
    end else if (bit_tick) begin
      if (load) begin
        frame_n = {1'b1, load_char, 1'b0};
        cnt_n   = '0;
        busy_n  = 1'b1;
      end else if (busy_q) begin
        if (cnt_q == LAST_CNT) begin
          busy_n = 1'b0;
        end else begin
          frame_n = {1'b1, frame_q[FRAME_W-1:1]};
          cnt_n   = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '1;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
    end else begin
      frame_q <= frame_n;
      cnt_q   <= cnt_n;
      busy_q  <= busy_n;
    end
  end

  assign busy     = busy_q;
  assign last     = busy_q & (cnt_q == LAST_CNT);
  assign line_bit = frame_q[0];

  // R2
  tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_tick && !abort) |=> ($stable(frame_q) && $stable(busy_q)));

  // R7
  abort_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy_q);
endmodule

// File: rtl/uartb_seq.sv
`timescale 1ns/1ps
module uartb_seq
  import uartb_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] wr_char,
  input  cmd_strb_t         strb,
  input  logic              sh_busy,
  input  logic              sh_last,
  output logic              load,
  output logic [DATA_W-1:0] load_char,
  output logic              abort,
  output logic              brk_on,
  output logic              tx_ready,
  output logic              tx_empty,
  output logic              brk_delta,
  output logic              mptr_p,
  output logic              rxrst_p,
  output logic              errrst_p
);
  logic              tx_en_q, tx_en_n;
  logic              hold_v_q, hold_v_n;
  logic [DATA_W-1:0] hold_d_q, hold_d_n;
  logic              brk_pend_q, brk_pend_n;
  logic              brk_on_q, brk_on_n;
  logic              stop_pend_q, stop_pend_n;
  logic              guard_q, guard_n;
  logic              delta_q, delta_n;
  logic              mptr_q, rxrst_q, errrst_q;
  logic              free, brk_go, en_after_rst;

  always_comb begin
    en_after_rst = strb.txrst ? 1'b0 : tx_en_q;
    if (strb.txon)       tx_en_n = 1'b1;
    else if (strb.txoff) tx_en_n = 1'b0;
    else                 tx_en_n = en_after_rst;

    free   = ~sh_busy | sh_last;
    brk_go = bit_tick & free & brk_pend_q;
    load   = bit_tick & free & ~brk_pend_q & ~brk_on_q & ~stop_pend_q &
             ~guard_q & hold_v_q & tx_en_q & ~strb.txrst & ~strb.txoff;
    abort  = strb.txrst;

    hold_v_n = hold_v_q;
    hold_d_n = hold_d_q;
    if (strb.txrst | strb.txoff) begin
      hold_v_n = 1'b0;
    end else if (load) begin
      hold_v_n = 1'b0;
    end else if (data_wr & tx_en_q & ~hold_v_q) begin
      hold_v_n = 1'b1;
      hold_d_n = wr_char;
    end

    brk_pend_n  = brk_pend_q;
    brk_on_n    = brk_on_q;
    stop_pend_n = stop_pend_q;
    guard_n     = guard_q;
    if (bit_tick & guard_q)     guard_n = 1'b0;
    if (bit_tick & stop_pend_q) begin
      brk_on_n    = 1'b0;
      stop_pend_n = 1'b0;
      guard_n     = 1'b1;
    end
    if (brk_go) begin
      brk_on_n   = 1'b1;
      brk_pend_n = 1'b0;
    end
    if (strb.brkon & tx_en_n & ~brk_on_q & ~brk_pend_q) brk_pend_n = 1'b1;
    if (strb.brkoff) begin
      brk_pend_n  = 1'b0;
      stop_pend_n = brk_on_q | brk_go;
    end

    if (brk_on_n != brk_on_q) delta_n = 1'b1;
    else if (strb.dbclr)      delta_n = 1'b0;
    else                      delta_n = delta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en_q     <= 1'b0;
      hold_v_q    <= 1'b0;
      hold_d_q    <= '0;
      brk_pend_q  <= 1'b0;
      brk_on_q    <= 1'b0;
      stop_pend_q <= 1'b0;
      guard_q     <= 1'b0;
      delta_q     <= 1'b0;
      mptr_q      <= 1'b0;
      rxrst_q     <= 1'b0;
      errrst_q    <= 1'b0;
    end else begin
      tx_en_q     <= tx_en_n;
      hold_v_q    <= hold_v_n;
      hold_d_q    <= hold_d_n;
      brk_pend_q  <= brk_pend_n;
      brk_on_q    <= brk_on_n;
      stop_pend_q <= stop_pend_n;
      guard_q     <= guard_n;
      delta_q     <= delta_n;
      mptr_q      <= strb.mptr;
      rxrst_q     <= strb.rxrst;
      errrst_q    <= strb.errrst;
    end
  end

  assign load_char = hold_d_q;
  assign brk_on    = brk_on_q;
  assign tx_ready  = tx_en_q & ~hold_v_q;
  assign tx_empty  = tx_en_q & ~hold_v_q & ~sh_busy;
  assign brk_delta = delta_q;
  assign mptr_p    = mptr_q;
  assign rxrst_p   = rxrst_q;
  assign errrst_p  = errrst_q;

  // R7
  txrst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.txrst && !strb.txon) |=> (!tx_en_q && !hold_v_q));

  // R3
  no_hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en_q |=> !hold_v_q);

  // R12
  delta_on_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_on_q) |-> delta_q);

  // R10
  brk_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.brkon && !tx_en_q && !strb.txon && !brk_pend_q) |=> !brk_pend_q);
endmodule

// File: rtl/uartb_tx_top.sv
`timescale 1ns/1ps
module uartb_tx_top
  import uartb_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [BUS_W-1:0] wr_data,
  output logic             txd,
  output logic             tx_ready,
  output logic             tx_empty,
  output logic             brk_delta,
  output logic             mode_ptr_rst,
  output logic             rx_rst,
  output logic             err_rst
);
  logic [1:0]        rst_sync_q;
  logic              rst_i_n;
  logic              data_wr;
  cmd_strb_t         strb;
  logic              load, abort, brk_on;
  logic [DATA_W-1:0] load_char;
  logic              sh_busy, sh_last, sh_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  uartb_cmd_dec dec_i (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .data_wr (data_wr),
    .strb    (strb)
  );

  uartb_seq #(.DATA_W(DATA_W)) seq_i (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .bit_tick  (bit_tick),
    .data_wr   (data_wr),
    .wr_char   (wr_data[DATA_W-1:0]),
    .strb      (strb),
    .sh_busy   (sh_busy),
    .sh_last   (sh_last),
    .load      (load),
    .load_char (load_char),
    .abort     (abort),
    .brk_on    (brk_on),
    .tx_ready  (tx_ready),
    .tx_empty  (tx_empty),
    .brk_delta (brk_delta),
    .mptr_p    (mode_ptr_rst),
    .rxrst_p   (rx_rst),
    .errrst_p  (err_rst)
  );

  uartb_shifter #(.DATA_W(DATA_W)) sh_i (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .bit_tick  (bit_tick),
    .load      (load),
    .load_char (load_char),
    .abort     (abort),
    .busy      (sh_busy),
    .last      (sh_last),
    .line_bit  (sh_bit)
  );

  always_comb begin
    if (brk_on)       txd = 1'b0;
    else if (sh_busy) txd = sh_bit;
    else              txd = 1'b1;
  end

  // R9
  no_load_in_break_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    brk_on |-> !load);
endmodule

// File: tb/uartb_tx_top_tb_top.sv
`timescale 1ns/1ps
module uartb_tx_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       txd, tx_ready, tx_empty, brk_delta, mode_ptr_rst, rx_rst, err_rst;
  int         total = 0;
  int         bad = 0;

  always #5 clk = ~clk;

  uartb_tx_top dut_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .txd(txd), .tx_ready(tx_ready),
    .tx_empty(tx_empty), .brk_delta(brk_delta), .mode_ptr_rst(mode_ptr_rst),
    .rx_rst(rx_rst), .err_rst(err_rst)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bit_tick = 1'b0;
    wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] b, input string req);
    for (int i = 0; i < 10; i++) begin
      logic e;
      tick();
      e = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : b[i-1];
      check(req, {31'd0, txd}, {31'd0, e});
    end
  endtask

  task automatic t_reset_state();
    hw_reset();
    check("R1 txd", txd, 1);
    check("R1 ready", tx_ready, 0);
    check("R1 empty", tx_empty, 0);
    check("R1 delta", brk_delta, 0);
    tick();
    check("R1 idle txd", txd, 1);
  endtask

  task automatic t_frame();
    hw_reset();
    wr(1, 8'h04);
    check("R4 ready", tx_ready, 1);
    check("R3 empty", tx_empty, 1);
    wr(0, 8'hA5);
    check("R3 ready full", tx_ready, 0);
    check("R3 empty full", tx_empty, 0);
    @(negedge clk);
    check("R2 no tick", txd, 1);
    frame(8'hA5, "R2 frame A5");
    tick();
    check("R2 idle", txd, 1);
    check("R3 empty end", tx_empty, 1);
  endtask

  task automatic t_hold_full();
    hw_reset();
    wr(0, 8'h44);
    wr(1, 8'h04);
    check("R3 disabled write ignored", tx_ready, 1);
    wr(0, 8'h11);
    tick();
    check("R2 start 11", txd, 0);
    check("R3 ready after load", tx_ready, 1);
    check("R3 empty while shifting", tx_empty, 0);
    wr(0, 8'h22);
    wr(0, 8'h33);
    check("R3 ready full", tx_ready, 0);
    repeat (9) tick();
    frame(8'h22, "R3 second char kept");
    tick();
    check("R3 third write dropped", txd, 1);
  endtask

  task automatic t_enable_disable();
    hw_reset();
    wr(1, 8'h04);
    wr(0, 8'h77);
    wr(1, 8'h04);
    check("R4 re-enable keeps hold", tx_ready, 0);
    wr(1, 8'h0C);
    check("R6 reserved when on", tx_ready, 0);
    frame(8'h77, "R4 held char sent");
    tick();
    wr(0, 8'h55);
    tick();
    check("R5 start", txd, 0);
    wr(0, 8'h66);
    wr(1, 8'h08);
    check("R5 ready clr", tx_ready, 0);
    check("R5 empty clr", tx_empty, 0);
    for (int i = 1; i < 10; i++) begin
      logic e;
      tick();
      e = (i == 9) ? 1'b1 : 8'h55 >> (i - 1);
      check("R5 drain", {31'd0, txd}, {31'd0, e});
    end
    tick();
    tick();
    check("R5 held dropped", txd, 1);
    wr(1, 8'h08);
    check("R5 disable twice", tx_ready, 0);
    wr(1, 8'h0C);
    check("R6 reserved when off", tx_ready, 0);
    wr(0, 8'h12);
    tick();
    check("R6 still off", txd, 1);
    wr(1, 8'h04);
    check("R4 enable after drain", tx_empty, 1);
  endtask

  task automatic t_txrst();
    hw_reset();
    wr(1, 8'h04);
    wr(0, 8'h0F);
    tick();
    tick();
    check("R7 mid frame", txd, 1);
    tick();
    check("R7 mid frame b1", txd, 1);
    wr(0, 8'h99);
    wr(1, 8'h30);
    tick();
    tick();
    check("R7 abort txd", txd, 1);
    check("R7 ready", tx_ready, 0);
    check("R7 empty", tx_empty, 0);
    wr(1, 8'h04);
    wr(0, 8'h00);
    tick();
    check("R7 start", txd, 0);
    wr(0, 8'hF0);
    wr(1, 8'h34);
    check("R7 abort txd now", txd, 1);
    check("R7 order ready", tx_ready, 1);
    check("R7 order empty", tx_empty, 1);
  endtask

  task automatic t_break_idle();
    hw_reset();
    wr(1, 8'h60);
    tick();
    check("R10 ignored off", txd, 1);
    check("R10 no delta", brk_delta, 0);
    wr(1, 8'h04);
    wr(1, 8'h60);
    check("R8 before tick", txd, 1);
    tick();
    check("R8 break", txd, 0);
    check("R12 set on start", brk_delta, 1);
    wr(1, 8'h50);
    check("R12 cleared", brk_delta, 0);
    tick();
    check("R8 held low", txd, 0);
    wr(1, 8'h70);
    check("R11 before tick", txd, 0);
    tick();
    check("R11 mark", txd, 1);
    check("R12 set on end", brk_delta, 1);
  endtask

  task automatic t_break_busy();
    hw_reset();
    wr(1, 8'h04);
    wr(0, 8'h3C);
    tick();
    check("R9 start", txd, 0);
    wr(0, 8'h81);
    wr(1, 8'h60);
    for (int i = 1; i < 10; i++) begin
      logic e;
      tick();
      e = (i == 9) ? 1'b1 : 8'h3C >> (i - 1);
      check("R9 frame finishes", {31'd0, txd}, {31'd0, e});
    end
    check("R9 no delta yet", brk_delta, 0);
    tick();
    check("R9 break after stop", txd, 0);
    check("R9 delta", brk_delta, 1);
    tick();
    check("R9 held waits", txd, 0);
    check("R9 hold full", tx_ready, 0);
    wr(1, 8'h50);
    wr(1, 8'h70);
    tick();
    check("R11 mark 1", txd, 1);
    check("R12 end delta", brk_delta, 1);
    tick();
    check("R11 mark 2", txd, 1);
    frame(8'h81, "R11 held after break");
  endtask

  task automatic t_pulses();
    hw_reset();
    wr(1, 8'h10);
    check("R13 mptr", mode_ptr_rst, 1);
    check("R13 rx quiet", rx_rst, 0);
    @(negedge clk);
    check("R13 mptr one cycle", mode_ptr_rst, 0);
    wr(1, 8'h20);
    check("R13 rx", rx_rst, 1);
    check("R13 err quiet", err_rst, 0);
    wr(1, 8'h40);
    check("R13 err", err_rst, 1);
    check("R13 rx one cycle", rx_rst, 0);
    wr(1, 8'h00);
    check("R13 nop", {29'd0, mode_ptr_rst, rx_rst, err_rst}, 0);
    check("R13 nop txd", txd, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_frame();
    t_hold_full();
    t_enable_disable();
    t_txrst();
    t_break_idle();
    t_break_busy();
    t_pulses();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule